// File: doc/BRIEF.md
# Strip Readout Command Interpreter

This block is the digital back end of one strip readout chip. A two-bit command bus selects one of four operating modes. In acquisition mode the block latches hit channels together with an amplitude. In clear mode it discards every latched hit and drops the token. In read mode it drains its latched hits onto a word output while it holds the readout token. In configure mode it shifts a per-channel kill mask and inject mask in from a serial line.

Each channel presents a discriminator hit bit and a flash comparator result as a thermometer vector. The block turns the thermometer vector into a binary amplitude by counting the unbroken run of ones from the lowest comparator, so bubbles above the run are ignored. Readout is zero suppressed. Chips are chained through a token: a chip starts sending only after the token reaches it, emits one word per clock from the lowest latched row upward, and then raises its token output for the next chip. Separate strobes re-arm the token stage and discard unread hits.

The state machine has three states. WAIT holds no token. SEND drains hits. PASS holds the token output high. The transitions are:
- WAIT→SEND when the token is taken with hits pending.
- WAIT→PASS when the token is taken with nothing pending.
- SEND→PASS when a read cycle finds nothing left.
- Any state→WAIT on the clear command or the token re-arm strobe.

Top module: `strip_readout_ctrl`

## Requirements
- R1: Command codes are 00 acquire, 01 clear, 10 read and 11 configure. Hits and inject hits are latched only on clocks where the command is 00. A latched channel keeps its first amplitude until it is read or cleared.
- R2: On each clock with command 11, one bit is shifted in from `cfg_bit`. After 2*N_CHAN such clocks, the first N_CHAN bits are the kill bits of channels 0 to N_CHAN-1 in that order, and the next N_CHAN bits are the inject bits of channels 0 to N_CHAN-1. Both masks are zero after `rst_n`.
- R3: A channel whose kill bit is 1 never latches a hit, even when its inject bit is 1.
- R4: A channel whose inject bit is 1 and kill bit is 0 latches a hit on every acquire clock, with amplitude N_LEVEL (7 by default), whatever its hit and thermometer inputs are.
- R5: A discriminator hit latches amplitude equal to the number of consecutive ones in its thermometer slice, counted from bit 0 up to the first zero. Channel c uses `therm_in[c*N_LEVEL +: N_LEVEL]`. Example: 1011011 gives 2.
- R6: Only latched channels produce words. They are sent one per clock in ascending row order, with `word_row` equal to the channel index.
- R7: No word is sent until `tok_in` is sampled high with command 10. If that edge is e0, word k becomes visible after edge e0+1+k.
- R8: `tok_out` rises after the edge that follows the edge producing the last word. If nothing is pending, it rises after the edge that samples the token. It is never high while a word is valid, and it stays high until a re-arm or a clear.
- R9: The clear command empties all latched hits, `word_valid` and `tok_out` at the next edge, and returns the block to waiting for a token.
- R10: `rd_rst` discards all latched hits at the next edge. A chip in the middle of sending then passes the token one clock later.
- R11: `tok_rst` returns the token stage to waiting at the next edge, with `tok_out` low and no word sent. Unread hits are kept for the next token.
- R12: After `rst_n`, `tok_out` and `word_valid` are low and no hit is latched.
- R13: Sending pauses on any clock whose command is not 10: no word is valid after such a clock. It resumes from the next pending row when the command returns to 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 2 | Command code |
| cfg_bit | input | 1 | Serial mask data, used in configure mode |
| hit_in | input | N_CHAN | Discriminator hit per channel |
| therm_in | input | N_CHAN*N_LEVEL | Thermometer flash result per channel |
| tok_in | input | 1 | Token from the previous chip |
| tok_rst | input | 1 | Token stage re-arm strobe |
| rd_rst | input | 1 | Discard unread hits |
| word_valid | output | 1 | A hit word is present |
| word_row | output | clog2(N_CHAN) | Row address of the word |
| word_amp | output | clog2(N_LEVEL+1) | Amplitude of the word |
| tok_out | output | 1 | Token to the next chip |

## Verification
A stale or lost pending bit shows at the ports in the next readout. It appears as an extra, missing or out-of-order row within one clock of the point where that row would have been sent. A wrong state shows either as a token raised while words are still pending, or as a token never raised, by the clock after the last expected word. Mask chain errors show in the same acquire-and-read sequence that follows configuration: a wrong channel is suppressed, or an amplitude other than full scale appears on an injected row.

// File: rtl/strip_ro_pkg.sv
package strip_ro_pkg;
    typedef enum logic [1:0] {
        CMD_ACQUIRE   = 2'b00,
        CMD_CLEAR     = 2'b01,
        CMD_READ      = 2'b10,
        CMD_CONFIGURE = 2'b11
    } ro_cmd_e;

    typedef enum logic [1:0] {
        RO_WAIT = 2'b00,
        RO_SEND = 2'b01,
        RO_PASS = 2'b10
    } ro_state_e;
endpackage

// File: rtl/therm_encoder.sv
module therm_encoder #(
    parameter int LEVELS = 7,
    parameter int AMP_W  = $clog2(LEVELS + 1)
) (
    input  logic [LEVELS-1:0] therm,
    output logic [AMP_W-1:0]  amp
);
    logic             run;
    logic [AMP_W-1:0] cnt;

    // Count the unbroken run of ones from the lowest comparator.
    always_comb begin
        run = 1'b1;
        cnt = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (run && therm[i]) begin
                cnt = cnt + AMP_W'(1);
            end else begin
                run = 1'b0;
            end
        end
        amp = cnt;
    end
endmodule

// File: rtl/mask_chain.sv
module mask_chain #(
    parameter int N_CHAN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [N_CHAN-1:0] kill_mask,
    output logic [N_CHAN-1:0] inject_mask
);
    localparam int CHAIN_LEN = 2 * N_CHAN;

    logic [CHAIN_LEN-1:0] chain;

    // New bits enter at the top, so the first bit ends at position 0.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else if (shift_en) begin
            chain <= {bit_in, chain[CHAIN_LEN-1:1]};
        end
    end

    assign kill_mask   = chain[N_CHAN-1:0];
    assign inject_mask = chain[CHAIN_LEN-1:N_CHAN];
endmodule

// File: rtl/hit_store.sv
module hit_store #(
    parameter int N_CHAN = 8,
    parameter int AMP_W  = 3,
    parameter int ROW_W  = $clog2(N_CHAN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     capture,
    input  logic [N_CHAN-1:0]        hit_eff,
    input  logic [N_CHAN*AMP_W-1:0]  amp_in,
    input  logic                     pop,
    output logic                     sel_valid,
    output logic [ROW_W-1:0]         sel_row,
    output logic [AMP_W-1:0]         sel_amp
);
    logic [N_CHAN-1:0] pending;
    logic [AMP_W-1:0]  amp_q [N_CHAN];

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        logic popped;
        assign popped = pop && (sel_row == ROW_W'(c));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pending[c] <= 1'b0;
                amp_q[c]   <= '0;
            end else if (flush) begin
                pending[c] <= 1'b0;
            end else if (popped) begin
                pending[c] <= 1'b0;
            end else if (capture && hit_eff[c] && !pending[c]) begin
                pending[c] <= 1'b1;
                amp_q[c]   <= amp_in[c*AMP_W +: AMP_W];
            end
        end
    end

    // Lowest pending row wins.
    always_comb begin
        sel_valid = 1'b0;
        sel_row   = '0;
        for (int i = N_CHAN - 1; i >= 0; i--) begin
            if (pending[i]) begin
                sel_valid = 1'b1;
                sel_row   = ROW_W'(i);
            end
        end
        sel_amp = amp_q[sel_row];
    end
endmodule

// File: rtl/readout_fsm.sv
module readout_fsm
    import strip_ro_pkg::*;
#(
    parameter int ROW_W = 3,
    parameter int AMP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_clear,
    input  logic             cmd_read,
    input  logic             tok_in,
    input  logic             tok_rst,
    input  logic             rd_rst,
    input  logic             sel_valid,
    input  logic [ROW_W-1:0] sel_row,
    input  logic [AMP_W-1:0] sel_amp,
    output logic             pop,
    output logic             word_valid,
    output logic [ROW_W-1:0] word_row,
    output logic [AMP_W-1:0] word_amp,
    output logic             tok_out
);
    ro_state_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RO_WAIT;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        if (cmd_clear || tok_rst) begin
            state_nxt = RO_WAIT;
        end else begin
            unique case (state)
                RO_WAIT: if (cmd_read && tok_in) state_nxt = sel_valid ? RO_SEND : RO_PASS;
                RO_SEND: if (cmd_read && !sel_valid) state_nxt = RO_PASS;
                RO_PASS: state_nxt = RO_PASS;
                default: state_nxt = RO_WAIT;
            endcase
        end
    end

    assign pop = (state == RO_SEND) && cmd_read && sel_valid && !rd_rst && !tok_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_row   <= '0;
            word_amp   <= '0;
        end else begin
            word_valid <= pop;
            if (pop) begin
                word_row <= sel_row;
                word_amp <= sel_amp;
            end
        end
    end

    always_comb begin
        tok_out = (state == RO_PASS);
    end
endmodule

// File: rtl/strip_readout_ctrl.sv
module strip_readout_ctrl
    import strip_ro_pkg::*;
#(
    parameter int N_CHAN  = 8,
    parameter int N_LEVEL = 7
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [1:0]                        cmd,
    input  logic                              cfg_bit,
    input  logic [N_CHAN-1:0]                 hit_in,
    input  logic [N_CHAN*N_LEVEL-1:0]         therm_in,
    input  logic                              tok_in,
    input  logic                              tok_rst,
    input  logic                              rd_rst,
    output logic                              word_valid,
    output logic [$clog2(N_CHAN)-1:0]         word_row,
    output logic [$clog2(N_LEVEL+1)-1:0]      word_amp,
    output logic                              tok_out
);
    localparam int ROW_W = $clog2(N_CHAN);
    localparam int AMP_W = $clog2(N_LEVEL + 1);

    logic cmd_acquire, cmd_clear, cmd_read, cmd_config;

    always_comb begin
        cmd_acquire = 1'b0;
        cmd_clear   = 1'b0;
        cmd_read    = 1'b0;
        cmd_config  = 1'b0;
        unique case (ro_cmd_e'(cmd))
            CMD_ACQUIRE:   cmd_acquire = 1'b1;
            CMD_CLEAR:     cmd_clear   = 1'b1;
            CMD_READ:      cmd_read    = 1'b1;
            CMD_CONFIGURE: cmd_config  = 1'b1;
            default:       cmd_acquire = 1'b0;
        endcase
    end

    logic [N_CHAN-1:0] kill_mask, inject_mask;

    mask_chain #(.N_CHAN(N_CHAN)) u_masks (
        .clk         (clk),
        .rst_n       (rst_n),
        .shift_en    (cmd_config),
        .bit_in      (cfg_bit),
        .kill_mask   (kill_mask),
        .inject_mask (inject_mask)
    );

    logic [N_CHAN-1:0]       hit_eff;
    logic [N_CHAN*AMP_W-1:0] amp_sel;

    for (genvar c = 0; c < N_CHAN; c++) begin : g_front
        logic [AMP_W-1:0] enc_amp;

        therm_encoder #(.LEVELS(N_LEVEL), .AMP_W(AMP_W)) u_enc (
            .therm (therm_in[c*N_LEVEL +: N_LEVEL]),
            .amp   (enc_amp)
        );

        assign hit_eff[c] = !kill_mask[c] && (hit_in[c] || inject_mask[c]);
        assign amp_sel[c*AMP_W +: AMP_W] = inject_mask[c] ? AMP_W'(N_LEVEL) : enc_amp;
    end

    logic             sel_valid, pop;
    logic [ROW_W-1:0] sel_row;
    logic [AMP_W-1:0] sel_amp;

    hit_store #(.N_CHAN(N_CHAN), .AMP_W(AMP_W), .ROW_W(ROW_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (cmd_clear || rd_rst),
        .capture   (cmd_acquire),
        .hit_eff   (hit_eff),
        .amp_in    (amp_sel),
        .pop       (pop),
        .sel_valid (sel_valid),
        .sel_row   (sel_row),
        .sel_amp   (sel_amp)
    );

    readout_fsm #(.ROW_W(ROW_W), .AMP_W(AMP_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_clear  (cmd_clear),
        .cmd_read   (cmd_read),
        .tok_in     (tok_in),
        .tok_rst    (tok_rst),
        .rd_rst     (rd_rst),
        .sel_valid  (sel_valid),
        .sel_row    (sel_row),
        .sel_amp    (sel_amp),
        .pop        (pop),
        .word_valid (word_valid),
        .word_row   (word_row),
        .word_amp   (word_amp),
        .tok_out    (tok_out)
    );
endmodule

// File: rtl/strip_readout_ctrl_chk.sv
module strip_readout_ctrl_chk #(
    parameter int ROW_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cmd,
    input logic             tok_rst,
    input logic             word_valid,
    input logic [ROW_W-1:0] word_row,
    input logic             tok_out
);
    assert_clear_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b01) |=> (!tok_out && !word_valid));

    assert_tok_rearm_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tok_rst |=> (!tok_out && !word_valid));

    assert_tok_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_out && !tok_rst && cmd != 2'b01) |=> tok_out);

    assert_word_without_tok_R8: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> !tok_out);

    assert_ascending_rows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && $past(word_valid)) |-> (word_row > $past(word_row)));

    assert_pause_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != 2'b10) |=> !word_valid);
endmodule

bind strip_readout_ctrl strip_readout_ctrl_chk #(.ROW_W(ROW_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .tok_rst    (tok_rst),
    .word_valid (word_valid),
    .word_row   (word_row),
    .tok_out    (tok_out)
);

// File: tb/test_strip_readout_ctrl.sv
module test_strip_readout_ctrl;
    localparam int N = 8;
    localparam int L = 7;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     cmd = 2'b00;
    logic           cfg_bit = 1'b0;
    logic [N-1:0]   hit_in = '0;
    logic [N*L-1:0] therm_in = '0;
    logic           tok_in = 1'b0;
    logic           tok_rst = 1'b0;
    logic           rd_rst = 1'b0;
    logic           word_valid;
    logic [2:0]     word_row;
    logic [2:0]     word_amp;
    logic           tok_out;

    int checks = 0;
    int errors = 0;
    int words_seen;

    bit      m_kill [N];
    bit      m_inj  [N];
    bit      m_pend [N];
    int      m_amp  [N];

    always #10 clk = ~clk;

    strip_readout_ctrl #(.N_CHAN(N), .N_LEVEL(L)) i_strip_readout_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .cfg_bit(cfg_bit), .hit_in(hit_in),
        .therm_in(therm_in), .tok_in(tok_in), .tok_rst(tok_rst), .rd_rst(rd_rst),
        .word_valid(word_valid), .word_row(word_row), .word_amp(word_amp), .tok_out(tok_out)
    );

    function automatic int run_len(logic [L-1:0] t);
        int n = 0;
        while (n < L && t[n]) n++;
        return n;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: update the expectation from the inputs seen at the edge.
    task automatic tick();
        if (cmd == 2'b00) begin
            for (int c = 0; c < N; c++) begin
                if (!m_kill[c] && (hit_in[c] || m_inj[c]) && !m_pend[c]) begin
                    m_pend[c] = 1;
                    m_amp[c]  = m_inj[c] ? L : run_len(therm_in[c*L +: L]);
                end
            end
        end
        if (cmd == 2'b01 || rd_rst) begin
            for (int c = 0; c < N; c++) m_pend[c] = 0;
        end
        @(posedge clk);
        #5;
    endtask

    task automatic load_masks(bit [N-1:0] k, bit [N-1:0] j);
        cmd = 2'b11;
        for (int i = 0; i < 2*N; i++) begin
            cfg_bit = (i < N) ? k[i] : j[i-N];
            tick();
        end
        cmd = 2'b00;
        cfg_bit = 1'b0;
        for (int c = 0; c < N; c++) begin
            m_kill[c] = k[c];
            m_inj[c]  = j[c];
        end
    endtask

    task automatic acquire(logic [N-1:0] h, logic [N*L-1:0] t);
        cmd = 2'b00;
        hit_in = h;
        therm_in = t;
        tick();
        hit_in = '0;
    endtask

    function automatic int lowest_pending();
        for (int c = 0; c < N; c++) if (m_pend[c]) return c;
        return -1;
    endfunction

    task automatic one_word();
        int c;
        c = lowest_pending();
        tick();
        check("R6 valid", word_valid, 1);
        check("R6 row", word_row, c);
        check(m_inj[c] ? "R4 amp" : "R5 amp", word_amp, m_amp[c]);
        m_pend[c] = 0;
        words_seen++;
    endtask

    task automatic take_token();
        words_seen = 0;
        cmd = 2'b10;
        tok_in = 1'b1;
        tick();
        tok_in = 1'b0;
        if (lowest_pending() < 0) begin
            check("R8 token at once", tok_out, 1);
        end else begin
            check("R7 no word yet", word_valid, 0);
            check("R7 token held", tok_out, 0);
        end
    endtask

    task automatic drain();
        while (lowest_pending() >= 0) one_word();
        tick();
        check("R8 last word done", word_valid, 0);
        check("R8 token passed", tok_out, 1);
    endtask

    task automatic rearm();
        tok_rst = 1'b1;
        tick();
        tok_rst = 1'b0;
        check("R11 token dropped", tok_out, 0);
        cmd = 2'b00;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int c = 0; c < N; c++) begin m_kill[c] = 0; m_inj[c] = 0; m_pend[c] = 0; m_amp[c] = 0; end
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        check("R12 tok_out", tok_out, 0);
        check("R12 word_valid", word_valid, 0);

        // R12 masks zero: every channel reads out. R5 bubble codes.
        acquire('1, {7'b1111111, 7'b0000000, 7'b0111110, 7'b1011011,
                     7'b0000001, 7'b0000011, 7'b1110111, 7'b0011111});
        check("R5 bubble code", m_amp[4], 2);
        take_token();
        drain();
        check("R12 all channels", words_seen, N);
        rearm();

        // R1 and R7: hits during read without token are not latched.
        cmd = 2'b10;
        hit_in = '1;
        tick();
        check("R7 no token no word", word_valid, 0);
        check("R7 no token no pass", tok_out, 0);
        hit_in = '0;
        take_token();
        check("R1 none latched", words_seen, 0);
        rearm();

        // R2, R3, R4: kill overrides inject, inject gives full scale.
        load_masks(8'b1111_0111, 8'b0010_1000);
        acquire('1, '0);
        take_token();
        drain();
        check("R3 only unkilled", words_seen, 1);
        rearm();
        load_masks('0, '0);

        // R9: clear command empties hits and drops a held token.
        acquire(8'b0101_0000, '1);
        cmd = 2'b01;
        tick();
        take_token();
        check("R9 hits cleared", words_seen, 0);
        cmd = 2'b01;
        tick();
        check("R9 token cleared", tok_out, 0);
        cmd = 2'b00;

        // R10: read reset mid-burst.
        acquire(8'b1001_0010, {N{7'b0000111}});
        take_token();
        one_word();
        rd_rst = 1'b1;
        tick();
        rd_rst = 1'b0;
        check("R10 word stopped", word_valid, 0);
        tick();
        check("R10 token passed", tok_out, 1);
        rearm();

        // R11: re-arm mid-burst keeps the rest.
        acquire(8'b1100_0001, {N{7'b0001111}});
        take_token();
        one_word();
        tok_rst = 1'b1;
        tick();
        tok_rst = 1'b0;
        check("R11 no word", word_valid, 0);
        check("R11 token low", tok_out, 0);
        take_token();
        drain();
        check("R11 rest kept", words_seen, 2);
        rearm();

        // R13: pause and resume.
        acquire(8'b0011_0100, {N{7'b0111111}});
        take_token();
        one_word();
        cmd = 2'b00;
        tick();
        check("R13 paused", word_valid, 0);
        tick();
        check("R13 still paused", word_valid, 0);
        cmd = 2'b10;
        drain();
        rearm();

        // Random traffic.
        for (int it = 0; it < 40; it++) begin
            if (($urandom % 4) == 0)
                load_masks(N'($urandom) & N'($urandom), N'($urandom) & N'($urandom) & N'($urandom));
            for (int a = 0; a < 1 + int'($urandom % 2); a++)
                acquire(N'($urandom) & N'($urandom), {$urandom, $urandom});
            take_token();
            drain();
            rearm();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule